// File: doc/BRIEF.md
# Sector Buffer Transfer Engine

This engine moves a run of consecutive sectors out of a NAND page that has already been opened by a page read command. Each sector is 512 data bytes plus 16 spare bytes. The engine copies each sector from the NAND byte port into one of four on-chip sector buffers, and a consumer reads the buffers out as a byte stream. The buffers form a ring indexed by the low two bits of the sector number. While sector j is filling from NAND, sector j-1 drains to the consumer, so both transfers run at the same time.

A run begins with a one-cycle start pulse that carries the sector count. The engine then selects the die. It pulses a checksum-enable strobe, and on the next cycle it launches the fill of buffer 0. Each launch is announced with a control word that encodes the target buffer. Before it launches the next fill, the engine waits until the current fill is complete and the previous drain has finished. After the last drain it releases the die and pulses done. Checking of the spare bytes is left to the logic downstream. This engine only raises the enable strobe.

Top module: `sector_xfer`

## Requirements
- R1: While reset is held and after it is released, chip_sel, ecc_en, ctl_launch, nand_ready, out_valid and done are all low.
- R2: A start pulse with sector_count N > 0 raises chip_sel and pulses ecc_en exactly once. The pulse appears in the cycle after start, and the first ctl_launch follows in the cycle after that.
- R3: A run issues exactly N ctl_launch pulses for sectors 0..N-1 in order. For sector j, ctl_word is 0xA24 with bits [4:3] replaced by (j mod 4).
- R4: The output carries exactly N×528 bytes. For each sector they are 512 data bytes and then 16 spare bytes, in the same order the bytes were accepted from the NAND port (nand_valid && nand_ready). nand_ready is never high while chip_sel is low.
- R5: out_last is high on the 528th byte of each sector and on no other byte.
- R6: The fill of sector j (j ≥ 1) is launched no later than the first output byte of sector j-1. With no back-pressure on either side, NAND bytes and output bytes move in the same cycle at some point during the run.
- R7: When out_valid is high and out_ready is low, out_valid stays high and out_data and out_last stay unchanged in the next cycle.
- R8: A fill never targets the buffer that is being drained or is starting to drain. Sector j is launched only after sector j-4 has been fully drained.
- R9: chip_sel stays high through every output byte of a run. It falls in the same cycle that done pulses, which is the cycle after the final output byte is accepted. done pulses exactly once per run.
- R10: A start with sector_count 0 pulses done in the next cycle. It produces no ecc_en, no ctl_launch, no output bytes, and chip_sel stays low.
- R11: A start pulse while a run is in progress is ignored. The run keeps its original count and produces a single done.
- R12: A run with sector_count 1 performs one launch and one drain and has no overlapped transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| sector_count | input | CNT_W | Number of sectors to move, sampled with start |
| nand_valid | input | 1 | NAND port has a byte on nand_byte |
| nand_byte | input | 8 | Byte from the open NAND page |
| nand_ready | output | 1 | A fill is in progress and takes a byte this cycle |
| ecc_en | output | 1 | One-cycle checksum-enable strobe at the start of a run |
| ctl_launch | output | 1 | One-cycle pulse marking a fill launch |
| ctl_word | output | 12 | Control word for the launch, holding the buffer index in [4:3] |
| out_valid | output | 1 | Stream byte available |
| out_ready | input | 1 | Consumer accepts the stream byte |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of a sector |
| chip_sel | output | 1 | Die select, held for the whole run |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
A wrong buffer index or a wrong byte offset shows up at the ports as an out_data mismatch. If a fill writes the wrong slot, the mismatch appears on the first byte of the drain that follows, within about 530 cycles. A ring pointer that wraps incorrectly first shows on sector 4, so the runs go past four sectors, and they also run under back-pressure from both sides. A stuck controller state is seen as a missing or extra ctl_launch, or as done arriving away from the cycle after the last byte. A broken hold of the stream shows up as duplicated or lost bytes, which changes the byte count.

// File: rtl/sxfer_pkg.sv
// Shared constants and types for the sector buffer transfer engine.
package sxfer_pkg;
    localparam int          CTL_W       = 12;
    localparam logic [11:0] CTL_BASE    = 12'hA24;
    localparam int          CTL_IDX_LSB = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_TAIL = 2'd3
    } xfer_state_e;
endpackage

// File: rtl/sxfer_bufmem.sv
// Sector buffer storage: NUM_BUFS data areas and NUM_BUFS spare areas.
// Assumes DATA_BYTES and SPARE_BYTES are powers of two with SPARE_BYTES < DATA_BYTES.
// A sector position below DATA_BYTES lands in the data area, and the rest lands in the spare area.
module sxfer_bufmem #(
    parameter int DATA_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int NUM_BUFS    = 4,
    localparam int IDX_W = $clog2(NUM_BUFS),
    localparam int DP_W  = $clog2(DATA_BYTES),
    localparam int SP_W  = $clog2(SPARE_BYTES),
    localparam int POS_W = DP_W + 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_buf,
    input  logic [POS_W-1:0] wr_pos,
    input  logic [7:0]       wr_byte,
    input  logic [IDX_W-1:0] rd_buf,
    input  logic [POS_W-1:0] rd_pos,
    output logic [7:0]       rd_byte
);
    logic [7:0] dmem [NUM_BUFS*DATA_BYTES];
    logic [7:0] smem [NUM_BUFS*SPARE_BYTES];

    logic [IDX_W+DP_W-1:0] wd_addr, rd_daddr;
    logic [IDX_W+SP_W-1:0] ws_addr, rd_saddr;

    assign wd_addr  = {wr_buf, wr_pos[DP_W-1:0]};
    assign ws_addr  = {wr_buf, wr_pos[SP_W-1:0]};
    assign rd_daddr = {rd_buf, rd_pos[DP_W-1:0]};
    assign rd_saddr = {rd_buf, rd_pos[SP_W-1:0]};

    // Write the incoming byte into the data or spare area of the target buffer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_pos[DP_W]) smem[ws_addr] <= wr_byte;
            else              dmem[wd_addr] <= wr_byte;
        end
    end

    // Asynchronous read of the byte at the drain position.
    always_comb begin
        rd_byte = rd_pos[DP_W] ? smem[rd_saddr] : dmem[rd_daddr];
    end
endmodule

// File: rtl/sxfer_fill.sv
// Fill unit: after a launch, takes SEC_BYTES bytes from the NAND port into one buffer.
// fill_rdy goes high when the sector is complete and stays high until the next launch.
// Assumes the launch is never asserted while a fill is still active.
module sxfer_fill #(
    parameter int DATA_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int NUM_BUFS    = 4,
    localparam int IDX_W = $clog2(NUM_BUFS),
    localparam int POS_W = $clog2(DATA_BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [IDX_W-1:0] launch_buf,
    input  logic             nand_valid,
    input  logic [7:0]       nand_byte,
    output logic             nand_ready,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_buf,
    output logic [POS_W-1:0] wr_pos,
    output logic [7:0]       wr_byte,
    output logic             fill_rdy
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(DATA_BYTES + SPARE_BYTES - 1);

    logic             active_q;
    logic [IDX_W-1:0] buf_q;
    logic [POS_W-1:0] pos_q;

    // Step the byte position on each accepted NAND byte and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            buf_q    <= '0;
            pos_q    <= '0;
            fill_rdy <= 1'b0;
        end else if (launch) begin
            active_q <= 1'b1;
            buf_q    <= launch_buf;
            pos_q    <= '0;
            fill_rdy <= 1'b0;
        end else if (active_q && nand_valid) begin
            if (pos_q == LAST_POS) begin
                active_q <= 1'b0;
                fill_rdy <= 1'b1;
                pos_q    <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    assign nand_ready = active_q;
    assign wr_en      = active_q && nand_valid;
    assign wr_buf     = buf_q;
    assign wr_pos     = pos_q;
    assign wr_byte    = nand_byte;
endmodule

// File: rtl/sxfer_drain.sv
// Drain unit: streams one buffer as data bytes and then spare bytes using valid/ready.
// Assumes go is asserted only while the unit is idle.
module sxfer_drain #(
    parameter int DATA_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int NUM_BUFS    = 4,
    localparam int IDX_W = $clog2(NUM_BUFS),
    localparam int POS_W = $clog2(DATA_BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [IDX_W-1:0] go_buf,
    input  logic [7:0]       rd_byte,
    input  logic             out_ready,
    output logic [IDX_W-1:0] rd_buf,
    output logic [POS_W-1:0] rd_pos,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             busy,
    output logic             finish
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(DATA_BYTES + SPARE_BYTES - 1);

    logic             active_q;
    logic [IDX_W-1:0] buf_q;
    logic [POS_W-1:0] pos_q;
    logic             at_last;

    assign at_last = (pos_q == LAST_POS);

    // Move the read position forward on each accepted output byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            buf_q    <= '0;
            pos_q    <= '0;
        end else if (go) begin
            active_q <= 1'b1;
            buf_q    <= go_buf;
            pos_q    <= '0;
        end else if (active_q && out_ready) begin
            if (at_last) begin
                active_q <= 1'b0;
                pos_q    <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    assign rd_buf    = buf_q;
    assign rd_pos    = pos_q;
    assign out_valid = active_q;
    assign out_data  = rd_byte;
    assign out_last  = active_q && at_last;
    assign busy      = active_q;
    assign finish    = active_q && out_ready && at_last;
endmodule

// File: rtl/sector_xfer.sv
// Top of the sector buffer transfer engine. The controller launches a fill of
// buffer (j mod NUM_BUFS) as soon as the previous fill is complete and the drain
// unit is idle. In the same cycle it starts draining the buffer filled just before.
// Assumes the page read has completed before start. NUM_BUFS must be at most 4,
// because the buffer index occupies bits [4:3] of ctl_word.
module sector_xfer
    import sxfer_pkg::*;
#(
    parameter int DATA_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int NUM_BUFS    = 4,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] sector_count,
    input  logic             nand_valid,
    input  logic [7:0]       nand_byte,
    output logic             nand_ready,
    output logic             ecc_en,
    output logic             ctl_launch,
    output logic [11:0]      ctl_word,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             chip_sel,
    output logic             done
);
    localparam int IDX_W = $clog2(NUM_BUFS);
    localparam int POS_W = $clog2(DATA_BYTES) + 1;

    xfer_state_e      state_q;
    logic [CNT_W-1:0] total_q, launched_q;
    logic             fill_rdy, drain_busy, drain_fin;
    logic             slot_free, do_launch, do_drain;
    logic [IDX_W-1:0] launch_idx, drain_idx;

    logic             wr_en;
    logic [IDX_W-1:0] wr_buf, rd_buf;
    logic [POS_W-1:0] wr_pos, rd_pos;
    logic [7:0]       wr_byte, rd_byte;

    // Decide launches and drains for this cycle.
    always_comb begin
        slot_free  = fill_rdy && !drain_busy;
        do_drain   = (state_q == ST_RUN) && slot_free;
        do_launch  = (state_q == ST_ARM) ||
                     (do_drain && (launched_q < total_q));
        launch_idx = (state_q == ST_ARM) ? '0 : launched_q[IDX_W-1:0];
        drain_idx  = launched_q[IDX_W-1:0] - IDX_W'(1);
    end

    // Run sequencing, die select and the one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            total_q    <= '0;
            launched_q <= '0;
            chip_sel   <= 1'b0;
            ecc_en     <= 1'b0;
            ctl_launch <= 1'b0;
            ctl_word   <= CTL_BASE;
            done       <= 1'b0;
        end else begin
            ecc_en     <= 1'b0;
            ctl_launch <= 1'b0;
            done       <= 1'b0;
            if (do_launch) begin
                ctl_launch <= 1'b1;
                ctl_word   <= CTL_BASE | (CTL_W'(launch_idx) << CTL_IDX_LSB);
            end
            unique case (state_q)
                ST_IDLE: if (start) begin
                    if (sector_count == '0) begin
                        done <= 1'b1;
                    end else begin
                        total_q  <= sector_count;
                        chip_sel <= 1'b1;
                        ecc_en   <= 1'b1;
                        state_q  <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    launched_q <= CNT_W'(1);
                    state_q    <= ST_RUN;
                end
                ST_RUN: if (do_drain) begin
                    if (do_launch) launched_q <= launched_q + 1'b1;
                    else           state_q    <= ST_TAIL;
                end
                ST_TAIL: if (drain_fin) begin
                    chip_sel <= 1'b0;
                    done     <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    sxfer_fill #(.DATA_BYTES(DATA_BYTES), .SPARE_BYTES(SPARE_BYTES), .NUM_BUFS(NUM_BUFS)) u_fill (
        .clk(clk), .rst_n(rst_n), .launch(do_launch), .launch_buf(launch_idx),
        .nand_valid(nand_valid), .nand_byte(nand_byte), .nand_ready(nand_ready),
        .wr_en(wr_en), .wr_buf(wr_buf), .wr_pos(wr_pos), .wr_byte(wr_byte),
        .fill_rdy(fill_rdy)
    );

    sxfer_bufmem #(.DATA_BYTES(DATA_BYTES), .SPARE_BYTES(SPARE_BYTES), .NUM_BUFS(NUM_BUFS)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_buf(wr_buf), .wr_pos(wr_pos), .wr_byte(wr_byte),
        .rd_buf(rd_buf), .rd_pos(rd_pos), .rd_byte(rd_byte)
    );

    sxfer_drain #(.DATA_BYTES(DATA_BYTES), .SPARE_BYTES(SPARE_BYTES), .NUM_BUFS(NUM_BUFS)) u_drain (
        .clk(clk), .rst_n(rst_n), .go(do_drain), .go_buf(drain_idx), .rd_byte(rd_byte),
        .out_ready(out_ready), .rd_buf(rd_buf), .rd_pos(rd_pos), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .busy(drain_busy), .finish(drain_fin)
    );
endmodule

// File: rtl/sector_xfer_chk.sv
// Property checker for sector_xfer, attached by bind below.
module sector_xfer_chk #(
    parameter int NUM_BUFS = 4,
    localparam int IDX_W = $clog2(NUM_BUFS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             nand_ready,
    input logic             ecc_en,
    input logic             ctl_launch,
    input logic [11:0]      ctl_word,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_last,
    input logic             chip_sel,
    input logic             done,
    input logic             do_launch,
    input logic             do_drain,
    input logic [IDX_W-1:0] launch_idx,
    input logic [IDX_W-1:0] drain_idx,
    input logic             drain_busy,
    input logic [IDX_W-1:0] rd_buf
);
    AST_ECC_BEFORE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_en |=> ctl_launch); // R2
    AST_WORD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_launch |-> ((ctl_word & ~12'h018) == 12'hA24)); // R3
    AST_NAND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_sel |-> !nand_ready); // R4
    AST_LAST_IN_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R5
    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R7
    AST_NO_CLOBBER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (do_launch && drain_busy) |-> (launch_idx != rd_buf)); // R8
    AST_NO_CLOBBER_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (do_launch && do_drain) |-> (launch_idx != drain_idx)); // R8
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !chip_sel); // R9
    AST_STREAM_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> chip_sel); // R9
endmodule

bind sector_xfer sector_xfer_chk #(.NUM_BUFS(NUM_BUFS)) u_chk (
    .clk(clk), .rst_n(rst_n), .nand_ready(nand_ready), .ecc_en(ecc_en),
    .ctl_launch(ctl_launch), .ctl_word(ctl_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .chip_sel(chip_sel), .done(done), .do_launch(do_launch), .do_drain(do_drain),
    .launch_idx(launch_idx), .drain_idx(drain_idx), .drain_busy(drain_busy),
    .rd_buf(rd_buf)
);

// File: tb/sector_xfer_tb.sv
module sector_xfer_tb;
    localparam int SEC = 528;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] sector_count = '0;
    logic       nand_valid = 1'b0;
    logic [7:0] nand_byte = '0;
    logic       out_ready = 1'b0;
    logic       nand_ready, ecc_en, ctl_launch, out_valid, out_last, chip_sel, done;
    logic [11:0] ctl_word;
    logic [7:0]  out_data;

    always #10 clk = ~clk;

    sector_xfer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sector_count(sector_count),
        .nand_valid(nand_valid), .nand_byte(nand_byte), .nand_ready(nand_ready),
        .ecc_en(ecc_en), .ctl_launch(ctl_launch), .ctl_word(ctl_word),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .chip_sel(chip_sel), .done(done)
    );

    int checks = 0, errors = 0;
    int cyc = 0, mode = 0, g_nand = 0, base = 0;
    bit nand_pend = 0;
    int rx, data_bad, bad_act, bad_exp, last_bad, last_cnt, cs_bad, cs_hi, stall_cnt, overlap;
    int ecc_cnt, ecc_cyc, lc, done_cnt, done_cyc, start_cyc, last_out_cyc;
    bit start_seen, cs_at_done;
    int launch_cyc [16];
    int word_rec [16];
    int first_out [16];
    int last_out [16];

    function automatic logic [7:0] byte_of(int g);
        return 8'((g * 31 + (g >>> 9)) & 255);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Port-side models and monitors, all sampled on the falling edge.
    always @(negedge clk) begin
        bit nhs, ohs;
        cyc++;
        if (cyc > 180000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 180000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
        if (nand_pend) g_nand++;
        nand_valid = mode[0] ? ((cyc % 3) != 0) : 1'b1;
        nand_byte  = byte_of(g_nand);
        nhs = nand_valid && nand_ready;
        nand_pend = nhs;
        out_ready = mode[1] ? ((cyc % 7) > 2) : 1'b1;
        ohs = out_valid && out_ready;
        if (out_valid && !out_ready) stall_cnt++;
        if (nhs && ohs) overlap++;
        if (chip_sel) cs_hi++;
        if (ohs) begin
            if (out_data !== byte_of(base + rx) && data_bad == 0) begin
                bad_act = out_data; bad_exp = byte_of(base + rx);
            end
            if (out_data !== byte_of(base + rx)) data_bad++;
            if (out_last !== ((rx % SEC) == SEC - 1)) last_bad++;
            if (out_last) last_cnt++;
            if (!chip_sel) cs_bad++;
            if ((rx / SEC) < 16) begin
                if ((rx % SEC) == 0) first_out[rx / SEC] = cyc;
                last_out[rx / SEC] = cyc;
            end
            last_out_cyc = cyc;
            rx++;
        end
        if (start && !start_seen) begin start_seen = 1; start_cyc = cyc; end
        if (ecc_en) begin ecc_cnt++; ecc_cyc = cyc; end
        if (ctl_launch) begin
            if (lc < 16) begin launch_cyc[lc] = cyc; word_rec[lc] = ctl_word; end
            lc++;
        end
        if (done) begin done_cnt++; done_cyc = cyc; cs_at_done = chip_sel; end
    end

    task automatic run_case(int n, int m, bit poke);
        int waited = 0;
        int bad_k;
        @(posedge clk); #2;
        mode = m; base = g_nand;
        rx = 0; data_bad = 0; last_bad = 0; last_cnt = 0; cs_bad = 0; cs_hi = 0;
        stall_cnt = 0; overlap = 0; ecc_cnt = 0; lc = 0; done_cnt = 0;
        start_seen = 0; cs_at_done = 1; done_cyc = -1; ecc_cyc = -1; last_out_cyc = -1;
        for (int k = 0; k < 16; k++) begin
            launch_cyc[k] = -1; first_out[k] = -1; last_out[k] = -1; word_rec[k] = -1;
        end
        start = 1; sector_count = 8'(n);
        @(posedge clk); #2; start = 0;
        if (poke) begin
            repeat (200) @(posedge clk);
            #2; start = 1; sector_count = 8'(n + 3);
            @(posedge clk); #2; start = 0;
        end
        while (done_cnt == 0 && waited < 40000) begin @(posedge clk); waited++; end
        repeat (6) @(posedge clk);
        #2;
        if (n == 0) begin
            chk(done_cnt == 1 && done_cyc == start_cyc + 1, "R10", "done one cycle after zero start", done_cyc - start_cyc, 1);
            chk(lc == 0 && ecc_cnt == 0 && rx == 0, "R10", "no launch/ecc/bytes", lc + ecc_cnt + rx, 0);
            chk(cs_hi == 0, "R10", "chip_sel stays low", cs_hi, 0);
            return;
        end
        chk(data_bad == 0, "R4", "stream byte value", bad_act, bad_exp);
        chk(rx == n * SEC, "R4", "stream byte count", rx, n * SEC);
        chk(last_bad == 0 && last_cnt == n, "R5", "out_last placement", last_cnt, n);
        chk(lc == n, "R3", "launch count", lc, n);
        bad_k = -1;
        for (int k = 0; k < n && k < 16; k++)
            if (word_rec[k] != (12'hA24 | ((k % 4) << 3))) bad_k = k;
        chk(bad_k < 0, "R3", "control word", (bad_k < 0) ? 0 : word_rec[bad_k],
            (bad_k < 0) ? 0 : (12'hA24 | ((bad_k % 4) << 3)));
        chk(ecc_cnt == 1 && ecc_cyc == start_cyc + 1, "R2", "ecc_en one pulse after start", ecc_cyc - start_cyc, 1);
        chk(launch_cyc[0] == start_cyc + 2, "R2", "first launch after ecc", launch_cyc[0] - start_cyc, 2);
        chk(cs_bad == 0, "R9", "chip_sel during stream", cs_bad, 0);
        chk(done_cnt == 1 && done_cyc == last_out_cyc + 1 && cs_at_done == 0, "R9",
            "done/release after final byte", done_cyc - last_out_cyc, 1);
        if (n >= 2) begin
            bad_k = -1;
            for (int k = 1; k < n && k < 16; k++)
                if (launch_cyc[k] < 0 || launch_cyc[k] > first_out[k-1]) bad_k = k;
            chk(bad_k < 0, "R6", "next fill launched before drain", bad_k, -1);
            if (m == 0) chk(overlap > 0, "R6", "overlapped transfer cycles", overlap, 1);
        end
        if (n >= 5) begin
            bad_k = -1;
            for (int k = 4; k < n && k < 16; k++)
                if (launch_cyc[k] <= last_out[k-4]) bad_k = k;
            chk(bad_k < 0, "R8", "reuse only after drain", bad_k, -1);
        end
        if (m[1]) chk(stall_cnt > 0 && data_bad == 0, "R7", "stream held under back-pressure", stall_cnt, 1);
        if (n == 1) chk(lc == 1 && overlap == 0, "R12", "single sector no overlap", overlap, 0);
        if (poke) chk(done_cnt == 1 && lc == n, "R11", "start ignored while busy", lc, n);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2;
        chk({chip_sel, ecc_en, ctl_launch, nand_ready, out_valid, done} == 6'b0, "R1",
            "outputs in reset", int'({chip_sel, ecc_en, ctl_launch, nand_ready, out_valid, done}), 0);
        rst_n = 1;
        repeat (3) @(posedge clk);
        #2;
        chk({chip_sel, ecc_en, ctl_launch, nand_ready, out_valid, done} == 6'b0, "R1",
            "outputs after reset", int'({chip_sel, ecc_en, ctl_launch, nand_ready, out_valid, done}), 0);
        run_case(0, 0, 0);
        run_case(1, 0, 0);
        run_case(1, 3, 0);
        run_case(2, 0, 0);
        run_case(3, 1, 0);
        run_case(4, 2, 0);
        run_case(5, 3, 0);
        run_case(6, 0, 0);
        run_case(9, 3, 0);
        run_case(9, 0, 0);
        run_case(4, 0, 1);
        run_case(0, 2, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule